// File: doc/BRIEF.md
# Synthesizer Divider Setting Loader

This block captures and holds the programmable settings of a clock synthesizer. There are three settings: a 9-bit feedback divide value, a 2-bit output divide select and a 3-bit test select. Settings can arrive over a wide parallel bus that is gated by an active-low strobe. They can also arrive over a three-wire serial link made of a shift clock, a data line and a load strobe. Both paths write the same holding register.

All strobes and the shift clock are slow, asynchronous board-level signals. Each is passed through a two-flop synchronizer into the system clock domain. Every update then happens on a system clock edge, a fixed few cycles after the external transition.

The last stage of the serial shift register is brought out so that it can drive a test output. A flag reports whether the held feedback value lies in the range where the loop can lock.

Top module: `synth_cfg_loader`

## Requirements
- R1: During reset and in the first cycle after it, the held feedback value equals `par_m`, the output select equals `par_n`, `test_sel` is 000 and the shift register is cleared, so `ser_out` is 0.
- R2: While `par_load_n` is low, `m_out` and `n_out` follow `par_m` and `par_n` within a few system clocks.
- R3: After `par_load_n` goes from low to high, the values present at that transition are held, and later changes on `par_m` and `par_n` have no effect.
- R4: While `par_load_n` is high, each rising edge of `ser_clk` shifts `ser_data` into the shift register's least significant end. `ser_out` is the most significant of the 14 stages, so after 14 shifts it shows the first bit sent.
- R5: A serial frame is 14 bits sent most significant first: test select bits 2..0, then output select bits 1..0, then feedback value bits 8..0. A rising edge of `ser_load` copies the whole frame into `test_sel`, `n_out` and `m_out`.
- R6: While `ser_load` is high, each rising edge of `ser_clk` writes the low 9 bits of the newly shifted register into `m_out`. `n_out` and `test_sel` are left unchanged.
- R7: With `par_load_n` high and `ser_load` low, the held values do not change, whether or not shifting takes place. This covers the time after the falling edge of `ser_load`.
- R8: While `par_load_n` is low, `test_sel` reads 000.
- R9: `m_valid` is high exactly when `m_out` lies in 125..360 inclusive.
- R10: While `par_load_n` is low, `ser_clk` edges do not shift the register, so `ser_out` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| par_load_n | input | 1 | Parallel load strobe, active low, asynchronous |
| par_m | input | 9 | Parallel feedback divide value |
| par_n | input | 2 | Parallel output divide select |
| ser_clk | input | 1 | Serial shift clock, asynchronous |
| ser_data | input | 1 | Serial data |
| ser_load | input | 1 | Serial load strobe, asynchronous |
| m_out | output | 9 | Held feedback divide value |
| n_out | output | 2 | Held output divide select |
| test_sel | output | 3 | Held test select |
| m_valid | output | 1 | Held feedback value is within the lock range |
| ser_out | output | 1 | Last shift register stage |

## Verification
The bench builds the block with its default widths (9, 2 and 3 bits) and the default lock window of 125 to 360. With 9 bits, every one of the 512 feedback values can be swept through the parallel path, so both edges of the validity window and each output select value are covered. With a 3-bit test field, one full serial frame can be sent for each of the eight test select codes. A model shift register kept in the bench predicts the pass-through values when the serial strobe is held high.

// File: rtl/synth_cfg_pkg.sv
package synth_cfg_pkg;
  localparam int M_W     = 9;
  localparam int N_W     = 2;
  localparam int T_W     = 3;
  localparam int FRAME_W = T_W + N_W + M_W;

  typedef struct packed {
    logic [T_W-1:0] t;
    logic [N_W-1:0] n;
    logic [M_W-1:0] m;
  } cfg_t;
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] lvl,
  output logic [W-1:0] rise
);
  logic [W-1:0] stg [STAGES];
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= d;
  end

  for (genvar k = 1; k < STAGES; k++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[k] <= '0;
      else     stg[k] <= stg[k-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= stg[STAGES-1];
  end

  assign lvl  = stg[STAGES-1];
  assign rise = stg[STAGES-1] & ~prev_q;
endmodule

// File: rtl/cfg_shift.sv
module cfg_shift #(
  parameter int W = 14
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift_en,
  input  logic         din,
  output logic [W-1:0] sr_q,
  output logic [W-1:0] sr_nxt
);
  assign sr_nxt = {sr_q[W-2:0], din};

  always_ff @(posedge clk) begin
    if (rst)           sr_q <= '0;
    else if (shift_en) sr_q <= sr_nxt;
  end

  assert_no_shift_R10: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(sr_q));
endmodule

// File: rtl/cfg_hold.sv
module cfg_hold
  import synth_cfg_pkg::*;
#(
  parameter int M_MIN = 125,
  parameter int M_MAX = 360
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               pl_n,
  input  logic               ld,
  input  logic               ld_rise,
  input  logic               sclk_rise,
  input  logic [M_W-1:0]     par_m,
  input  logic [N_W-1:0]     par_n,
  input  logic [FRAME_W-1:0] sr_q,
  input  logic [FRAME_W-1:0] sr_nxt,
  output logic [M_W-1:0]     m_q,
  output logic [N_W-1:0]     n_q,
  output logic [T_W-1:0]     t_q,
  output logic               m_valid_q
);
  cfg_t frame_now, frame_shift;
  logic [M_W-1:0] m_nxt;
  logic [N_W-1:0] n_nxt;
  logic [T_W-1:0] t_nxt;

  assign frame_now   = cfg_t'(sr_q);
  assign frame_shift = cfg_t'(sr_nxt);

  always_comb begin
    m_nxt = m_q;
    n_nxt = n_q;
    t_nxt = t_q;
    if (rst || !pl_n) begin
      m_nxt = par_m;
      n_nxt = par_n;
      t_nxt = '0;
    end else if (ld_rise) begin
      m_nxt = frame_now.m;
      n_nxt = frame_now.n;
      t_nxt = frame_now.t;
    end else if (ld && sclk_rise) begin
      m_nxt = frame_shift.m;
    end
  end

  always_ff @(posedge clk) begin
    m_q       <= m_nxt;
    n_q       <= n_nxt;
    t_q       <= t_nxt;
    m_valid_q <= (int'(m_nxt) >= M_MIN) && (int'(m_nxt) <= M_MAX);
  end

  assert_test_zero_R8: assert property (@(posedge clk) disable iff (rst)
    !pl_n |=> (t_q == '0));
  assert_valid_window_R9: assert property (@(posedge clk) disable iff (rst)
    m_valid_q == ((int'(m_q) >= M_MIN) && (int'(m_q) <= M_MAX)));
  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (pl_n && !ld_rise && !(ld && sclk_rise)) |=>
      ($stable(m_q) && $stable(n_q) && $stable(t_q)));
  assert_pass_keeps_nt_R6: assert property (@(posedge clk) disable iff (rst)
    (pl_n && ld && !ld_rise && sclk_rise) |=> ($stable(n_q) && $stable(t_q)));
endmodule

// File: rtl/synth_cfg_loader.sv
module synth_cfg_loader
  import synth_cfg_pkg::*;
#(
  parameter int M_MIN       = 125,
  parameter int M_MAX       = 360,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           par_load_n,
  input  logic [M_W-1:0] par_m,
  input  logic [N_W-1:0] par_n,
  input  logic           ser_clk,
  input  logic           ser_data,
  input  logic           ser_load,
  output logic [M_W-1:0] m_out,
  output logic [N_W-1:0] n_out,
  output logic [T_W-1:0] test_sel,
  output logic           m_valid,
  output logic           ser_out
);
  localparam int NSIG = 4;
  localparam int I_SCLK = 0, I_SDAT = 1, I_LOAD = 2, I_PLN = 3;

  logic [NSIG-1:0] raw, lvl, rise;
  logic [FRAME_W-1:0] sr_q, sr_nxt;

  assign raw = {par_load_n, ser_load, ser_data, ser_clk};

  cfg_sync #(.W(NSIG), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst), .d(raw), .lvl(lvl), .rise(rise)
  );

  cfg_shift #(.W(FRAME_W)) shift_i (
    .clk(clk), .rst(rst),
    .shift_en(lvl[I_PLN] && rise[I_SCLK]),
    .din(lvl[I_SDAT]),
    .sr_q(sr_q), .sr_nxt(sr_nxt)
  );

  cfg_hold #(.M_MIN(M_MIN), .M_MAX(M_MAX)) hold_i (
    .clk(clk), .rst(rst),
    .pl_n(lvl[I_PLN]), .ld(lvl[I_LOAD]), .ld_rise(rise[I_LOAD]),
    .sclk_rise(rise[I_SCLK]),
    .par_m(par_m), .par_n(par_n),
    .sr_q(sr_q), .sr_nxt(sr_nxt),
    .m_q(m_out), .n_q(n_out), .t_q(test_sel), .m_valid_q(m_valid)
  );

  assign ser_out = sr_q[FRAME_W-1];
endmodule

// File: tb/synth_cfg_loader_tb_top.sv
module synth_cfg_loader_tb_top;
  logic clk = 0;
  logic rst = 1;
  logic par_load_n = 1;
  logic [8:0] par_m = 9'd200;
  logic [1:0] par_n = 2'd2;
  logic ser_clk = 0, ser_data = 0, ser_load = 0;
  logic [8:0] m_out;
  logic [1:0] n_out;
  logic [2:0] test_sel;
  logic m_valid, ser_out;

  int checks = 0;
  int errors = 0;
  logic [13:0] model_sr = '0;

  always #10 clk = ~clk;

  synth_cfg_loader dut_i (
    .clk(clk), .rst(rst), .par_load_n(par_load_n), .par_m(par_m), .par_n(par_n),
    .ser_clk(ser_clk), .ser_data(ser_data), .ser_load(ser_load),
    .m_out(m_out), .n_out(n_out), .test_sel(test_sel), .m_valid(m_valid),
    .ser_out(ser_out)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    ser_data = b;
    tick(4);
    ser_clk = 1;
    tick(4);
    ser_clk = 0;
    tick(4);
    model_sr = {model_sr[12:0], b};
  endtask

  task automatic send_frame(input logic [13:0] w);
    for (int i = 13; i >= 0; i--) send_bit(w[i]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [13:0] w;
    logic [1:0] hn;
    logic [2:0] ht;
    tick(3);
    // R1: reset state
    check("R1 m", int'(m_out), 200);
    check("R1 n", int'(n_out), 2);
    check("R1 t", int'(test_sel), 0);
    check("R1 ser_out", int'(ser_out), 0);
    rst = 0;
    tick(1);
    check("R1 m after release", int'(m_out), 200);
    check("R1 ser_out after release", int'(ser_out), 0);

    // R2 / R9 / R8: parallel sweep over every feedback value
    par_load_n = 0;
    tick(5);
    for (int i = 0; i < 512; i++) begin
      par_m = 9'(i);
      par_n = 2'(i % 4);
      tick(2);
      check("R2 m", int'(m_out), i);
      check("R2 n", int'(n_out), i % 4);
      check("R9 valid", int'(m_valid), (i >= 125 && i <= 360) ? 1 : 0);
      check("R8 t", int'(test_sel), 0);
    end

    // R3: capture on rising strobe, later inputs ignored
    par_m = 9'd300; par_n = 2'd1;
    tick(3);
    par_load_n = 1;
    tick(6);
    par_m = 9'd17; par_n = 2'd3;
    tick(6);
    check("R3 m", int'(m_out), 300);
    check("R3 n", int'(n_out), 1);

    // R4 / R5 / R7: one frame per test select code
    for (int tv = 0; tv < 8; tv++) begin
      w = {3'(tv), 2'((tv + 1) % 4), 9'(100 + tv * 37)};
      hn = n_out; ht = test_sel;
      send_frame(w);
      check("R4 ser_out", int'(ser_out), int'(w[13]));
      check("R7 m before load", int'(m_out), (tv == 0) ? 300 : 100 + (tv - 1) * 37);
      ser_load = 1;
      tick(6);
      check("R5 m", int'(m_out), 100 + tv * 37);
      check("R5 n", int'(n_out), (tv + 1) % 4);
      check("R5 t", int'(test_sel), tv);
      ser_load = 0;
      tick(6);
      check("R7 m after fall", int'(m_out), 100 + tv * 37);
    end

    // R6: strobe held high, each shift passes into m
    ser_load = 1;
    tick(6);
    hn = model_sr[10:9]; ht = model_sr[13:11];
    check("R6 reload m", int'(m_out), int'(model_sr[8:0]));
    for (int k = 0; k < 9; k++) begin
      send_bit(logic'((k * 5 + 1) % 3 == 0));
      check("R6 m pass", int'(m_out), int'(model_sr[8:0]));
      check("R6 n kept", int'(n_out), int'(hn));
      check("R6 t kept", int'(test_sel), int'(ht));
    end
    w[8:0] = model_sr[8:0];
    ser_load = 0;
    tick(6);
    send_bit(1); send_bit(0); send_bit(1);
    check("R7 m frozen", int'(m_out), int'(w[8:0]));

    // R10 / R8: alternating frame, then parallel mode ignores shifts
    send_frame(14'b10101010101010);
    check("R4 ser_out alt", int'(ser_out), 1);
    par_m = 9'd360; par_n = 2'd0;
    par_load_n = 0;
    tick(6);
    check("R8 t parallel", int'(test_sel), 0);
    check("R2 m again", int'(m_out), 360);
    check("R9 valid 360", int'(m_valid), 1);
    for (int k = 0; k < 3; k++) begin
      ser_data = 0; tick(4); ser_clk = 1; tick(4); ser_clk = 0; tick(4);
      check("R10 ser_out held", int'(ser_out), 1);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule